// File: doc/BRIEF.md
# IPv4 Header Checksum Engine

This block produces the 16-bit header checksum for a transmit path that sends IPv4 headers of fixed form. The header is always 20 bytes long. Version, header length, service type, the don't-fragment flag word, time to live, protocol and total length are constants fixed by parameter. Only three things change from one packet to the next: the identification number, the source address and the destination address. Before the header bytes go out, the serialiser pulses `start_i` once. It holds a valid identification and both addresses in the cycle of that pulse.

The engine captures the variable words at the start edge and sets its accumulator to the constant part of the sum, which is already reduced to 16 bits when the design is built. It then adds one variable word per cycle for five cycles. In a final cycle it folds the carries back in with end-around addition, inverts the result and registers it. A one-cycle `done_o` pulse marks the new value. The value on `csum_o` stays put until the next calculation finishes.

Top module: `ipv4_hdr_csum`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no start, `csum_o` is 16'h0000 and `done_o` is 0. A reset in the middle of a calculation cancels it, so no `done_o` pulse follows.
- R2: The `csum_o` published with `done_o` is the bitwise inverse of the ones'-complement sum of the ten header words, taken in this order: {4'h4, 4'h5, TOS}, total length, identification, 16'h4000, {TTL, PROTO}, 16'h0000, source[31:16], source[15:0], destination[31:16], destination[15:0].
- R3: The total length word equals 76 + PAYLOAD_BYTES, which is 20 header bytes plus 8 UDP bytes plus 48 bytes of inner header plus the payload.
- R4: `done_o` is high for exactly one cycle. It is seen at the seventh rising edge after the edge that samples `start_i` high in the idle state, which is the eighth cycle when the start cycle counts as the first.
- R5: A `start_i` pulse that arrives while a calculation is running is ignored. No extra `done_o` appears, and the result belongs to the calculation that was accepted.
- R6: The identification and address inputs are sampled only at the edge that accepts a start. Changing them later has no effect on the result.
- R7: `csum_o` keeps its value in every cycle in which `done_o` is low.
- R8: Carry folding is end-around complete. If the first fold produces a new carry, that carry is added in before inversion. For example, ident 16'h7611 with source 32'hFFFF0000 and destination 32'h00010000 gives 16'hFFFE under the default parameters.
- R9: A start that is sampled in the same cycle as a `done_o` pulse is accepted and runs a full new calculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to compute a new checksum |
| ident_i | input | 16 | IPv4 identification field |
| src_addr_i | input | 32 | Source IPv4 address, big-endian |
| dst_addr_i | input | 32 | Destination IPv4 address, big-endian |
| csum_o | output | 16 | Registered header checksum |
| done_o | output | 1 | One-cycle pulse marking a new `csum_o` |

## Verification
Each accumulator error corrupts the very next published checksum, seven edges after the start. Examples are a lost word, a word added twice, a wrong preload or a truncated fold. The bench catches these by comparing every result against a model that is written separately and sums all ten header words. A controller that slips out of sequence shows up as a `done_o` pulse at the wrong edge, a missing pulse, or an extra pulse after an ignored start. A bad capture path shows up only when the inputs are changed after the start.

// File: rtl/ipv4_csum_pkg.sv
package ipv4_csum_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SUM,
    ST_CARRY_ADD
  } csum_state_e;

  // identification + two source words + two destination words
  localparam int unsigned VAR_WORDS = 5;

  function automatic logic [15:0] fold16(input logic [31:0] s);
    logic [31:0] t;
    t = s;
    for (int i = 0; i < 3; i++) t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    return t[15:0];
  endfunction

endpackage

// File: rtl/ipv4_csum_word_shift.sv
module ipv4_csum_word_shift #(
  parameter int unsigned NUM_WORDS = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      shift_i,
  input  logic [NUM_WORDS*16-1:0]   words_i,
  output logic [15:0]               word_o
);

  logic [15:0] w_q [NUM_WORDS];

  // first word sits in the top slice of words_i
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_slot
    logic [15:0] nxt;
    if (i == NUM_WORDS - 1) begin : g_tail
      assign nxt = 16'h0;
    end else begin : g_body
      assign nxt = w_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      w_q[i] <= 16'h0;
      else if (load_i)  w_q[i] <= words_i[16*(NUM_WORDS-i)-1 -: 16];
      else if (shift_i) w_q[i] <= nxt;
    end
  end

  assign word_o = w_q[0];

  // R6: captured words move only on load or shift
  a_r6_words_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(word_o));

endmodule

// File: rtl/ipv4_csum_ctrl.sv
module ipv4_csum_ctrl
  import ipv4_csum_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic add_o,
  output logic finish_o
);

  localparam int unsigned CNT_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  csum_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_word;

  assign last_word = (cnt_q == CNT_W'(NUM_WORDS - 1));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    load_o   = 1'b0;
    add_o    = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          state_d = ST_SUM;
        end
      end
      ST_SUM: begin
        add_o = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (last_word) state_d = ST_CARRY_ADD;
      end
      ST_CARRY_ADD: begin
        finish_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R5: a running calculation is never abandoned for a new start
  a_r5_sum_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUM) |=> (state_q != ST_IDLE));

  // R4: fold stage lasts one cycle and always follows the sum stage
  a_r4_fold_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CARRY_ADD) |=> (state_q == ST_IDLE));

  a_r4_fold_after_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_CARRY_ADD) |-> ($past(state_q) == ST_SUM));

endmodule

// File: rtl/ipv4_csum_accum.sv
module ipv4_csum_accum #(
  parameter int unsigned    ACC_W   = 19,
  parameter logic [15:0]    PRELOAD = 16'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        add_i,
  input  logic        finish_i,
  input  logic [15:0] word_i,
  output logic [15:0] csum_o,
  output logic        done_o
);

  logic [ACC_W-1:0] acc_q;
  logic [16:0]      fold1;
  logic [15:0]      fold2;

  // end-around fold: second add absorbs a carry from the first
  assign fold1 = {1'b0, acc_q[15:0]} + 17'(acc_q[ACC_W-1:16]);
  assign fold2 = fold1[15:0] + {15'h0, fold1[16]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (init_i) acc_q <= ACC_W'(PRELOAD);
    else if (add_i)  acc_q <= acc_q + ACC_W'(word_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csum_o <= 16'h0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) csum_o <= ~fold2;
    end
  end

  // R7: result changes only alongside a done pulse
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(csum_o));

  // R4: done is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/ipv4_hdr_csum.sv
module ipv4_hdr_csum
  import ipv4_csum_pkg::*;
#(
  parameter int unsigned PAYLOAD_BYTES = 1424,
  parameter logic [7:0]  TOS           = 8'h00,
  parameter logic [7:0]  TTL           = 8'hFF,
  parameter logic [7:0]  PROTO         = 8'h11
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [15:0] ident_i,
  input  logic [31:0] src_addr_i,
  input  logic [31:0] dst_addr_i,
  output logic [15:0] csum_o,
  output logic        done_o
);

  localparam int unsigned TOTAL_LEN = 20 + 8 + 48 + PAYLOAD_BYTES;
  localparam logic [31:0] CONST_SUM = {16'h0, 8'h45, TOS} + {16'h0, 16'(TOTAL_LEN)}
                                    + 32'h0000_4000 + {16'h0, TTL, PROTO};
  localparam logic [15:0] PRELOAD   = fold16(CONST_SUM);
  // room for preload plus every variable word without losing a carry
  localparam int unsigned ACC_W     = 16 + $clog2(VAR_WORDS + 1);

  logic        load, add, finish;
  logic [15:0] word;

  ipv4_csum_ctrl #(
    .NUM_WORDS (VAR_WORDS)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .load_o   (load),
    .add_o    (add),
    .finish_o (finish)
  );

  ipv4_csum_word_shift #(
    .NUM_WORDS (VAR_WORDS)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (add),
    .words_i ({ident_i, src_addr_i, dst_addr_i}),
    .word_o  (word)
  );

  ipv4_csum_accum #(
    .ACC_W   (ACC_W),
    .PRELOAD (PRELOAD)
  ) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (load),
    .add_i    (add),
    .finish_i (finish),
    .word_i   (word),
    .csum_o   (csum_o),
    .done_o   (done_o)
  );

  // R4: accepted start produces done seven edges later
  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> ##7 done_o);

endmodule

// File: tb/ipv4_hdr_csum_tb_top.sv
module ipv4_hdr_csum_tb_top;

  localparam int unsigned PAYLOAD = 1424;
  localparam logic [7:0]  TOS_V   = 8'h00;
  localparam logic [7:0]  TTL_V   = 8'hFF;
  localparam logic [7:0]  PROTO_V = 8'h11;

  // {ident, src, dst}
  localparam int NV = 6;
  localparam logic [79:0] VECS [NV] = '{
    {16'h0000, 32'h0000_0000, 32'h0000_0000},
    {16'h1234, 32'hC0A8_0001, 32'hC0A8_00C7},
    {16'hFFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {16'h7611, 32'hFFFF_0000, 32'h0001_0000},
    {16'hABCD, 32'h0A00_0001, 32'h0A00_00FE},
    {16'h0001, 32'h7F00_0001, 32'hE000_0001}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ident_i = '0;
  logic [31:0] src_addr_i = '0;
  logic [31:0] dst_addr_i = '0;
  logic [15:0] csum_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ipv4_hdr_csum #(
    .PAYLOAD_BYTES (PAYLOAD),
    .TOS           (TOS_V),
    .TTL           (TTL_V),
    .PROTO         (PROTO_V)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ident_i    (ident_i),
    .src_addr_i (src_addr_i),
    .dst_addr_i (dst_addr_i),
    .csum_o     (csum_o),
    .done_o     (done_o)
  );

  function automatic logic [15:0] model(input logic [15:0] id, input logic [31:0] s,
                                        input logic [31:0] d);
    logic [31:0] acc;
    acc = {16'h0, 8'h45, TOS_V} + (76 + PAYLOAD) + id + 32'h4000 + {16'h0, TTL_V, PROTO_V}
        + s[31:16] + s[15:0] + d[31:16] + d[15:0];
    while (acc[31:16] != 0) acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
    return ~acc[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts at a negedge; returns at the negedge where done seen; lat = negedges waited
  task automatic run(input logic [79:0] v, output int lat);
    ident_i    = v[79:64];
    src_addr_i = v[63:32];
    dst_addr_i = v[31:0];
    start_i    = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start_i = 1'b0;
      lat++;
    end while (!done_o && lat < 20);
  endtask

  initial begin
    int lat;
    logic [15:0] held;
    // R1: reset state
    #1;
    check("R1 csum in reset", csum_o, 16'h0);
    check("R1 done in reset", done_o, 1'b0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 csum after reset", csum_o, 16'h0);
    check("R1 done after reset", done_o, 1'b0);

    // R2 R3 R4 R8: table walk
    for (int i = 0; i < NV; i++) begin
      run(VECS[i], lat);
      check("R4 latency", lat, 7);
      check("R2 R3 R8 checksum", csum_o, model(VECS[i][79:64], VECS[i][63:32], VECS[i][31:0]));
      @(negedge clk);
      check("R4 single pulse", done_o, 1'b0);
    end

    // R8: double-carry vector, fixed expected value
    run(VECS[3], lat);
    check("R8 end-around fold", csum_o, 16'hFFFE);
    @(negedge clk);

    // R6: inputs changed after the start edge
    ident_i = 16'h1111; src_addr_i = 32'h0102_0304; dst_addr_i = 32'h0506_0708;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ident_i = 16'hDEAD; src_addr_i = 32'hBEEF_0000; dst_addr_i = 32'h0000_CAFE;
    lat = 1;
    while (!done_o && lat < 20) begin @(negedge clk); lat++; end
    check("R6 latency", lat, 7);
    check("R6 sampled at start", csum_o, model(16'h1111, 32'h0102_0304, 32'h0506_0708));

    // R7: result holds without start while inputs wander
    held = csum_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ident_i = ident_i + 16'h0101;
      src_addr_i = ~src_addr_i;
    end
    check("R7 hold csum", csum_o, held);
    check("R7 no done", done_o, 1'b0);

    // R5: second start during run is ignored
    ident_i = 16'h2222; src_addr_i = 32'h0A0B_0C0D; dst_addr_i = 32'h1020_3040;
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    ident_i = 16'h9999; src_addr_i = 32'hFFFF_0001; dst_addr_i = 32'h0;
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    lat = 3;
    while (!done_o && lat < 20) begin @(negedge clk); lat++; end
    check("R5 first run latency", lat, 7);
    check("R5 first run result", csum_o, model(16'h2222, 32'h0A0B_0C0D, 32'h1020_3040));
    begin
      int extra = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (done_o) extra++;
      end
      check("R5 no extra done", extra, 0);
    end

    // R9: back-to-back start in the done cycle
    run(VECS[1], lat);
    run(VECS[4], lat);
    check("R9 back-to-back latency", lat, 7);
    check("R9 back-to-back result", csum_o,
          model(VECS[4][79:64], VECS[4][63:32], VECS[4][31:0]));
    @(negedge clk);

    // R1: reset mid-run cancels the calculation
    held = csum_o;
    ident_i = 16'h4444; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 reset clears csum", csum_o, 16'h0);
    rst_ni = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (done_o) seen++;
      end
      check("R1 no done after mid-run reset", seen, 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule